// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block inspects the address field at the head of each received HDLC frame while the bytes stream in, one byte per accepted cycle. Frame boundaries arrive as start and end strobes on the first and last byte. Flags, bit stuffing and CRC have already been removed upstream. The block can read either a one-byte or a two-byte address field. It compares that field against two programmable high-byte registers, two programmable low-byte registers and two fixed high-byte values. From the result it decides whether the frame's payload goes to the receive FIFO, and whether the frame qualifies for automatic protocol handling.

A two-bit mode input picks the operating mode. The two recognising modes (automatic and non-automatic) filter on the address. The two transparent modes forward every byte without looking at it. An optional length guard counts bytes in units of 32. It stops forwarding once the programmed maximum is passed, and flags the frame as too long. At the end of every frame, a one-cycle report states:
- whether the frame matched;
- which registers matched;
- whether automatic handling applies;
- whether the length limit was exceeded.

Top module: `hdlc_addr_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, `fwd_valid` and `rpt_valid` are 0 and every report field is 0.
- R2: With `addr_2byte`=0 the first frame byte is compared with `cmp_lo1` and `cmp_lo2`. `rpt_lo_id` is 2'b01 for a `cmp_lo1` hit (which wins if both hit), 2'b10 for a `cmp_lo2`-only hit and 2'b00 for none. `rpt_hi_id` is 2'b00. The frame matches when `rpt_lo_id` is not 2'b00.
- R3: With `addr_2byte`=1 the first byte is the high address byte. It is checked against `cmp_hi1` (code 2'b01), then `cmp_hi2` (2'b10), then the fixed values 8'hFC or 8'hFE (2'b11), in that priority. The second byte is coded as in R2. The frame matches only when both codes are non-zero.
- R4: `rpt_auto` is 1 only in mode 2'b00, and only when either of these holds:
  - one-byte mode with low code 2'b01;
  - two-byte mode with high code 2'b01 and low code 2'b01.
  In every other case `rpt_auto` is 0.
- R5: In modes 2'b00 and 2'b01, each byte of a matched frame that follows the address field appears on `fwd_data` with `fwd_valid`=1 in the cycle after it was accepted. The address bytes themselves are never forwarded.
- R6: No byte of an unmatched frame is forwarded, and its report shows `rpt_match`=0. This also applies to a frame shorter than the address field.
- R7: In modes 2'b10 and 2'b11 every accepted byte, address included, is forwarded the next cycle. The report shows match 1, both codes 2'b00 and auto 0.
- R8: The cycle after the byte carrying `in_eof` is accepted, `rpt_valid` pulses for exactly one cycle with that frame's fields.
- R9: With `len_chk_en`=1, a frame may hold at most (`len_limit`+1)*32 bytes. Later bytes are not forwarded and `rpt_too_long` is 1. A frame of exactly that length is not flagged. With `len_chk_en`=0 no limit applies.
- R10: A valid byte arriving with no frame open is ignored: no forward and no report. A frame is open from an `in_sof` byte up to and including its `in_eof` byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| mode | input | 2 | 00 auto, 01 non-auto, 10 arbiter transparent, 11 extended transparent |
| addr_2byte | input | 1 | 1 selects a two-byte address field |
| cmp_hi1 | input | 8 | High-byte compare register 1 |
| cmp_hi2 | input | 8 | High-byte compare register 2 |
| cmp_lo1 | input | 8 | Low-byte compare register 1 |
| cmp_lo2 | input | 8 | Low-byte compare register 2, usable as broadcast |
| len_chk_en | input | 1 | Enables the length guard |
| len_limit | input | 7 | Maximum length in 32-byte units, minus one |
| fwd_valid | output | 1 | Forwarded byte strobe toward the receive FIFO |
| fwd_data | output | 8 | Forwarded byte |
| rpt_valid | output | 1 | End-of-frame report strobe |
| rpt_match | output | 1 | Frame accepted |
| rpt_hi_id | output | 2 | High-byte match code |
| rpt_lo_id | output | 2 | Low-byte match code |
| rpt_auto | output | 1 | Automatic handling applies |
| rpt_too_long | output | 1 | Length limit exceeded |

## Verification
The properties assume that `mode`, `addr_2byte`, the compare registers and the length settings change only between frames. They also assume that `in_sof` and `in_eof` are meaningful only together with `in_valid`. The stimulus reprograms these inputs only while no frame is open, and drives the strobes low whenever `in_valid` is low. Stray bytes outside any frame are sent on purpose, to exercise the ignore rule.

// File: rtl/hdlc_afilt_pkg.sv
`timescale 1ns/1ps
package hdlc_afilt_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO        = 2'b00,
        MODE_NONAUTO     = 2'b01,
        MODE_ARB_TRANSP  = 2'b10,
        MODE_EXT_TRANSP  = 2'b11
    } rx_mode_e;

    typedef logic [1:0] reg_id_t;

    localparam reg_id_t ID_NONE  = 2'b00;
    localparam reg_id_t ID_ONE   = 2'b01;
    localparam reg_id_t ID_TWO   = 2'b10;
    localparam reg_id_t ID_FIXED = 2'b11;

    localparam logic [7:0] FIXED_HI_A = 8'hFC;
    localparam logic [7:0] FIXED_HI_B = 8'hFE;

    typedef struct packed {
        logic    match;
        reg_id_t hi_id;
        reg_id_t lo_id;
        logic    auto_ok;
        logic    too_long;
    } frame_rpt_t;

    // Register 1 beats register 2, which beats the fixed values.
    function automatic reg_id_t pick_id(input logic [1:0] hits, input logic fixed_hit);
        if (hits[0])        return ID_ONE;
        else if (hits[1])   return ID_TWO;
        else if (fixed_hit) return ID_FIXED;
        else                return ID_NONE;
    endfunction

    function automatic logic is_bypass(input rx_mode_e m);
        return (m == MODE_ARB_TRANSP) || (m == MODE_EXT_TRANSP);
    endfunction

endpackage

// File: rtl/afilt_cmp.sv
`timescale 1ns/1ps
module afilt_cmp #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic [W-1:0]        sample,
    input  logic [N-1:0][W-1:0] refs,
    output logic [N-1:0]        hits
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = (sample == refs[g]);
    end
endmodule

// File: rtl/afilt_len.sv
`timescale 1ns/1ps
module afilt_len #(
    parameter int LIM_W     = 7,
    parameter int UNIT_LOG2 = 5,
    parameter int CNT_W     = LIM_W + UNIT_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             restart,
    input  logic             chk_en,
    input  logic [LIM_W-1:0] limit,
    output logic [CNT_W-1:0] pos,
    output logic [CNT_W-1:0] cnt_next,
    output logic             over
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] max_bytes;

    assign pos       = restart ? '0 : cnt_q;
    assign cnt_next  = (&pos) ? pos : pos + CNT_W'(1);
    assign max_bytes = (CNT_W'(limit) + CNT_W'(1)) << UNIT_LOG2;
    assign over      = step && chk_en && (cnt_next > max_bytes);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (step) cnt_q <= cnt_next;
    end
endmodule

// File: rtl/hdlc_addr_filter.sv
`timescale 1ns/1ps
module hdlc_addr_filter
    import hdlc_afilt_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LIM_W     = 7,
    parameter int UNIT_LOG2 = 5,
    parameter int N_REGS    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [1:0]        mode,
    input  logic              addr_2byte,
    input  logic [DATA_W-1:0] cmp_hi1,
    input  logic [DATA_W-1:0] cmp_hi2,
    input  logic [DATA_W-1:0] cmp_lo1,
    input  logic [DATA_W-1:0] cmp_lo2,
    input  logic              len_chk_en,
    input  logic [LIM_W-1:0]  len_limit,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic              rpt_valid,
    output logic              rpt_match,
    output logic [1:0]        rpt_hi_id,
    output logic [1:0]        rpt_lo_id,
    output logic              rpt_auto,
    output logic              rpt_too_long
);
    localparam int CNT_W = LIM_W + UNIT_LOG2 + 1;

    rx_mode_e   mode_e;
    logic       bypass;
    logic       frame_byte;
    logic       in_frame_q;
    reg_id_t    hi_q, lo_q;
    logic       cut_q;

    logic [N_REGS-1:0][DATA_W-1:0] hi_refs, lo_refs;
    logic [N_REGS-1:0]             hi_hits, lo_hits;
    logic                          fixed_hit;

    logic [CNT_W-1:0] pos, cnt_next, addr_len;
    logic             over;

    reg_id_t    hi_base, lo_base, hi_cur, lo_cur;
    logic       is_hi_pos, is_lo_pos;
    logic       addr_done, past_addr, addr_ok;
    frame_rpt_t rpt_cur, rpt_q;
    logic       fwd_n;

    assign mode_e     = rx_mode_e'(mode);
    assign bypass     = is_bypass(mode_e);
    assign frame_byte = in_valid && (in_sof || in_frame_q);

    assign hi_refs   = {cmp_hi2, cmp_hi1};
    assign lo_refs   = {cmp_lo2, cmp_lo1};
    assign fixed_hit = (in_data == DATA_W'(FIXED_HI_A)) || (in_data == DATA_W'(FIXED_HI_B));

    afilt_cmp #(.W(DATA_W), .N(N_REGS)) u_hi_cmp (
        .sample(in_data), .refs(hi_refs), .hits(hi_hits)
    );
    afilt_cmp #(.W(DATA_W), .N(N_REGS)) u_lo_cmp (
        .sample(in_data), .refs(lo_refs), .hits(lo_hits)
    );

    afilt_len #(.LIM_W(LIM_W), .UNIT_LOG2(UNIT_LOG2), .CNT_W(CNT_W)) u_len (
        .clk      (clk),
        .rst      (rst),
        .step     (frame_byte),
        .restart  (in_sof),
        .chk_en   (len_chk_en),
        .limit    (len_limit),
        .pos      (pos),
        .cnt_next (cnt_next),
        .over     (over)
    );

    // Address decode for the byte currently presented
    always_comb begin
        addr_len  = addr_2byte ? CNT_W'(2) : CNT_W'(1);
        is_hi_pos = addr_2byte && (pos == '0);
        is_lo_pos = addr_2byte ? (pos == CNT_W'(1)) : (pos == '0);
        hi_base   = in_sof ? ID_NONE : hi_q;
        lo_base   = in_sof ? ID_NONE : lo_q;
        hi_cur    = is_hi_pos ? pick_id(hi_hits[1:0], fixed_hit) : hi_base;
        lo_cur    = is_lo_pos ? pick_id(lo_hits[1:0], 1'b0) : lo_base;
        addr_done = (cnt_next >= addr_len);
        past_addr = (pos >= addr_len);
        addr_ok   = addr_2byte ? ((hi_cur != ID_NONE) && (lo_cur != ID_NONE))
                               : (lo_cur != ID_NONE);
    end

    // Routing and end-of-frame summary
    always_comb begin
        fwd_n = frame_byte && !over && (bypass || (past_addr && addr_ok));

        rpt_cur          = '0;
        rpt_cur.match    = bypass || (addr_done && addr_ok);
        rpt_cur.hi_id    = bypass ? ID_NONE : hi_cur;
        rpt_cur.lo_id    = bypass ? ID_NONE : lo_cur;
        rpt_cur.auto_ok  = (mode_e == MODE_AUTO) && addr_done &&
                           (addr_2byte ? ((hi_cur == ID_ONE) && (lo_cur == ID_ONE))
                                       : (lo_cur == ID_ONE));
        rpt_cur.too_long = (in_sof ? 1'b0 : cut_q) | over;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            hi_q       <= ID_NONE;
            lo_q       <= ID_NONE;
            cut_q      <= 1'b0;
            fwd_valid  <= 1'b0;
            fwd_data   <= '0;
            rpt_valid  <= 1'b0;
            rpt_q      <= '0;
        end else begin
            fwd_valid <= fwd_n;
            rpt_valid <= frame_byte && in_eof;
            if (fwd_n) fwd_data <= in_data;
            if (frame_byte) begin
                in_frame_q <= !in_eof;
                hi_q       <= hi_cur;
                lo_q       <= lo_cur;
                cut_q      <= rpt_cur.too_long;
                if (in_eof) rpt_q <= rpt_cur;
            end
        end
    end

    assign rpt_match    = rpt_valid && rpt_q.match;
    assign rpt_hi_id    = rpt_valid ? rpt_q.hi_id : 2'b00;
    assign rpt_lo_id    = rpt_valid ? rpt_q.lo_id : 2'b00;
    assign rpt_auto     = rpt_valid && rpt_q.auto_ok;
    assign rpt_too_long = rpt_valid && rpt_q.too_long;

endmodule

// File: rtl/afilt_chk.sv
`timescale 1ns/1ps
module afilt_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_eof,
    input logic [1:0] mode,
    input logic       addr_2byte,
    input logic       fwd_valid,
    input logic       rpt_valid,
    input logic       rpt_match,
    input logic [1:0] rpt_hi_id,
    input logic [1:0] rpt_lo_id,
    input logic       rpt_auto
);
    p_fwd_from_byte_r10: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> $past(in_valid));

    p_rpt_after_eof_r8: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |-> $past(in_valid && in_eof));

    p_auto_only_auto_r4: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_auto) |-> (rpt_match && ($past(mode) == 2'b00)));

    p_bypass_fields_r7: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && $past(mode[1])) |-> (rpt_match && rpt_hi_id == 2'b00 && rpt_lo_id == 2'b00 && !rpt_auto));

    p_one_byte_no_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && !$past(addr_2byte)) |-> (rpt_hi_id == 2'b00));

    p_match_has_low_r3: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_match && !$past(mode[1])) |-> (rpt_lo_id != 2'b00));
endmodule

bind hdlc_addr_filter afilt_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_eof(in_eof),
    .mode(mode), .addr_2byte(addr_2byte), .fwd_valid(fwd_valid),
    .rpt_valid(rpt_valid), .rpt_match(rpt_match), .rpt_hi_id(rpt_hi_id),
    .rpt_lo_id(rpt_lo_id), .rpt_auto(rpt_auto)
);

// File: tb/hdlc_addr_filter_bench.sv
`timescale 1ns/1ps
module hdlc_addr_filter_bench;
    logic       clk = 0;
    logic       rst = 1;
    logic       in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0] in_data = 0;
    logic [1:0] mode = 0;
    logic       addr_2byte = 0;
    logic [7:0] cmp_hi1 = 8'h11, cmp_hi2 = 8'h22, cmp_lo1 = 8'h33, cmp_lo2 = 8'hFF;
    logic       len_chk_en = 0;
    logic [6:0] len_limit = 0;
    logic       fwd_valid, rpt_valid, rpt_match, rpt_auto, rpt_too_long;
    logic [7:0] fwd_data;
    logic [1:0] rpt_hi_id, rpt_lo_id;

    int    n_tests = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference state
    int m_pos = 0, m_hi = 0, m_lo = 0;
    bit m_open = 0, m_cut = 0;

    always #2.5 clk = ~clk;

    hdlc_addr_filter u_hdlc_addr_filter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .mode(mode), .addr_2byte(addr_2byte),
        .cmp_hi1(cmp_hi1), .cmp_hi2(cmp_hi2), .cmp_lo1(cmp_lo1), .cmp_lo2(cmp_lo2),
        .len_chk_en(len_chk_en), .len_limit(len_limit),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .rpt_valid(rpt_valid),
        .rpt_match(rpt_match), .rpt_hi_id(rpt_hi_id), .rpt_lo_id(rpt_lo_id),
        .rpt_auto(rpt_auto), .rpt_too_long(rpt_too_long)
    );

    function automatic int lo_code(input logic [7:0] d);
        if (d == cmp_lo1) return 1;
        if (d == cmp_lo2) return 2;
        return 0;
    endfunction

    function automatic int hi_code(input logic [7:0] d);
        if (d == cmp_hi1) return 1;
        if (d == cmp_hi2) return 2;
        if (d == 8'hFC || d == 8'hFE) return 3;
        return 0;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, predict, compare after the rising edge
    task automatic cycle(input logic [7:0] d, input bit v, input bit s, input bit e);
        bit ef = 0, er = 0, em = 0, ea = 0, et = 0;
        int eh = 0, el = 0;
        @(negedge clk);
        in_valid = v; in_data = d; in_sof = v & s; in_eof = v & e;
        if (v && (s || m_open)) begin
            int idx, alen;
            bit ok, over, byp;
            if (s) begin m_pos = 0; m_hi = 0; m_lo = 0; m_cut = 0; end
            m_open = 1;
            idx = m_pos;
            m_pos++;
            if (addr_2byte) begin
                if (idx == 0) m_hi = hi_code(d);
                if (idx == 1) m_lo = lo_code(d);
            end else if (idx == 0) m_lo = lo_code(d);
            alen = addr_2byte ? 2 : 1;
            over = len_chk_en && (m_pos > (int'(len_limit) + 1) * 32);
            if (over) m_cut = 1;
            ok  = addr_2byte ? (m_hi != 0 && m_lo != 0) : (m_lo != 0);
            byp = mode[1];
            ef  = !over && (byp || (idx >= alen && ok));
            if (e) begin
                er = 1;
                em = byp || (m_pos >= alen && ok);
                eh = byp ? 0 : m_hi;
                el = byp ? 0 : m_lo;
                ea = (mode == 2'b00) && m_pos >= alen &&
                     (addr_2byte ? (m_hi == 1 && m_lo == 1) : (m_lo == 1));
                et = m_cut;
                m_open = 0;
            end
        end
        @(posedge clk); #1;
        check("fwd_valid", 32'(fwd_valid), 32'(ef));
        if (ef) check("fwd_data", 32'(fwd_data), 32'(d));
        check("rpt_valid", 32'(rpt_valid), 32'(er));
        if (er) begin
            check("rpt_match", 32'(rpt_match), 32'(em));
            check("rpt_hi_id", 32'(rpt_hi_id), 32'(eh));
            check("rpt_lo_id", 32'(rpt_lo_id), 32'(el));
            check("rpt_auto", 32'(rpt_auto), 32'(ea));
            check("rpt_too_long", 32'(rpt_too_long), 32'(et));
        end
    endtask

    task automatic frame(input logic [7:0] q[$]);
        foreach (q[i]) cycle(q[i], 1, i == 0, i == q.size() - 1);
        cycle(8'h00, 0, 0, 0);
    endtask

    task automatic long_frame(input int n, input logic [7:0] first);
        for (int i = 0; i < n; i++)
            cycle((i == 0) ? first : 8'(i), 1, i == 0, i == n - 1);
        cycle(8'h00, 0, 0, 0);
    endtask

    initial begin
        #750000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        check("fwd_valid in reset", 32'(fwd_valid), 0);
        check("rpt_valid in reset", 32'(rpt_valid), 0);
        check("rpt fields in reset", {26'd0, rpt_match, rpt_hi_id, rpt_lo_id, rpt_auto}, 0);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        check("fwd_valid after reset", 32'(fwd_valid), 0);
        check("rpt_valid after reset", 32'(rpt_valid), 0);

        // one-byte mode, auto
        mode = 2'b00; addr_2byte = 0;
        cur_req = "R2"; frame('{8'h33, 8'hA1, 8'hA2});
        cur_req = "R4"; frame('{8'h33, 8'h5A});
        cur_req = "R2"; frame('{8'hFF, 8'hB1, 8'hB2}); // broadcast register
        cur_req = "R6"; frame('{8'h44, 8'hC1, 8'hC2});
        cmp_lo2 = 8'h33;
        cur_req = "R2"; frame('{8'h33, 8'hC3});        // low priority
        cmp_lo2 = 8'hFF;
        cur_req = "R8"; frame('{8'h33});                // single byte frame

        // two-byte mode
        addr_2byte = 1;
        cur_req = "R3"; frame('{8'h11, 8'h33, 8'hD1, 8'hD2});
        cur_req = "R4"; frame('{8'hFE, 8'h33, 8'hD3});
        cur_req = "R3"; frame('{8'hFC, 8'hFF, 8'hD4});
        cur_req = "R3"; frame('{8'h22, 8'hFF, 8'hD5});
        cur_req = "R6"; frame('{8'h11, 8'h99, 8'hD6});
        cur_req = "R6"; frame('{8'h42, 8'h33, 8'hD7});
        cur_req = "R6"; frame('{8'h11});                // shorter than address
        cmp_hi2 = 8'h11;
        cur_req = "R3"; frame('{8'h11, 8'h33, 8'hD8});
        cmp_hi2 = 8'h22;

        // non-auto mode
        mode = 2'b01;
        cur_req = "R4"; frame('{8'h11, 8'h33, 8'hE1});
        cur_req = "R5"; frame('{8'h22, 8'h33, 8'hE2, 8'hE3, 8'hE4});

        // transparent modes
        mode = 2'b11;
        cur_req = "R7"; frame('{8'h01, 8'h02, 8'h03});
        mode = 2'b10; addr_2byte = 0;
        cur_req = "R7"; frame('{8'h77, 8'h78});

        // stray bytes outside a frame
        cur_req = "R10";
        cycle(8'h33, 1, 0, 0);
        cycle(8'h34, 1, 0, 1);
        cycle(8'h00, 0, 0, 0);

        // length guard
        mode = 2'b11; len_chk_en = 1; len_limit = 0;
        cur_req = "R9"; long_frame(40, 8'h10);
        cur_req = "R9"; long_frame(32, 8'h10);
        mode = 2'b00; len_limit = 1;
        cur_req = "R9"; long_frame(70, 8'h33);
        len_chk_en = 0;
        cur_req = "R9"; long_frame(70, 8'h33);
        cur_req = "R5"; frame('{8'h33, 8'hF1, 8'hF2});

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule